// File: doc/BRIEF.md
# I2C Clock Phase Sequencer

This block turns four programmable counts, all in reference-clock cycles, into the SCL waveform of an I2C master. It also gives the points at which the byte engine may change SDA. The counts are the whole bit period, the low share of that period, the hold/setup time used around bus conditions, and the data setup time ahead of each SCL rising edge. Each count is clamped to at least 1, so the counters always advance. For a bit period of P cycles, the low phase lasts L cycles and the high phase lasts P-L cycles, or a single cycle when L is not below P. A typical setting uses P = reference rate / bus rate (100 kHz by default, at most 400 kHz), L = 5P/9, a condition time of P/2 and a data setup of P/16.

The byte engine issues one command at a time on `cmd_valid`/`cmd_code`. A command is taken in any cycle in which `cmd_ready` is high. The block answers with single-cycle strobes: `tick_sda` (change SDA now), `tick_rise` (first cycle with SCL high), `tick_sample` (sample SDA now) and `tick_cond` (make the SDA edge of a START or STOP now).

The states are named as follows. ST_IDLE is a free bus with SCL high and takes only START. ST_EDGE is one cycle that carries `tick_cond`. ST_HOLD holds SCL high for the condition time after a START or repeated START. ST_OWN is the bus owned with SCL high and takes BIT, RSTART or STOP. ST_LOW is the low phase. ST_HIGH is the high phase of a data bit. ST_SETUP is SCL high for the condition time ahead of a repeated START or STOP. ST_BUSFREE is the bus-free wait after a STOP.

The transitions are: IDLE→EDGE on START; EDGE→HOLD, or EDGE→BUSFREE when the command is STOP; HOLD→OWN; OWN→LOW on BIT, RSTART or STOP; LOW→HIGH for BIT and LOW→SETUP otherwise; HIGH→OWN; SETUP→EDGE; BUSFREE→IDLE.

Top module: `scl_phase_gen`

## Requirements
- R1: After reset, `scl_o` is 1 and `cmd_ready` is 1, and no strobe is active.
- R2: A count of zero behaves exactly like a count of one. With all four counts zero, a data bit holds SCL low for 1 cycle and high for 1 cycle.
- R3: The command code is 0 for START. A START taken in cycle c gives `tick_cond` in cycle c+1 with SCL high. SCL then stays high for S further cycles, and `cmd_ready` returns in cycle c+S+2.
- R4: The command code is 1 for BIT. A BIT taken in cycle c pulls SCL low in cycles c+1..c+L. SCL is high from cycle c+L+1, with `tick_rise` in that cycle. `tick_sample` comes in cycle c+L+H, where H = P-L. `cmd_ready` returns in cycle c+L+H+1.
- R5: With D < L, `tick_sda` comes D cycles before the final low cycle, in cycle c+L-D. With D >= L, it comes in the first low cycle, c+1. It is never active while SCL is high.
- R6: The command code is 2 for RSTART. After the low phase, SCL rises in cycle c+L+1 with `tick_rise`. `tick_cond` follows in cycle c+L+S+1, and `cmd_ready` returns in cycle c+L+2S+2.
- R7: The command code is 3 for STOP. The cycles up to `tick_cond` in c+L+S+1 match R6. `cmd_ready` then stays low for a bus-free time of L cycles and returns in cycle c+2L+S+2.
- R8: A non-START command in ST_IDLE, or a START in ST_OWN, is ignored. It causes no strobe and no SCL change, and `cmd_ready` stays 1.
- R9: When L >= P, the high phase of a data bit is exactly one cycle, so `tick_rise` and `tick_sample` fall in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_period | input | CW | Bit period count P |
| cfg_low | input | CW | Low phase count L |
| cfg_cond | input | CW | Condition hold/setup count S |
| cfg_dsetup | input | CW | Data setup count D |
| cmd_valid | input | 1 | Command present |
| cmd_code | input | 2 | 0 START, 1 BIT, 2 RSTART, 3 STOP |
| cmd_ready | output | 1 | Command can be taken this cycle |
| scl_o | output | 1 | SCL level (1 = released) |
| tick_sda | output | 1 | Strobe: change SDA now |
| tick_rise | output | 1 | Strobe: first cycle of SCL high |
| tick_sample | output | 1 | Strobe: sample SDA now |
| tick_cond | output | 1 | Strobe: START/STOP SDA edge now |

## Verification
Two strobes can share a cycle. `tick_rise` and `tick_sample` coincide whenever the high phase collapses to one cycle. That happens either because the low count is not below the period or because every count is zero. `tick_sda` and the SCL fall coincide when the data setup is not below the low count. The bench provokes both cases with dedicated configurations. It predicts each strobe as a separate (cycle, kind) item and checks that the two coinciding items arrive together, in the same cycle and in the predicted order.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

    typedef enum logic [1:0] {
        CMD_START  = 2'd0,
        CMD_BIT    = 2'd1,
        CMD_RSTART = 2'd2,
        CMD_STOP   = 2'd3
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EDGE,
        ST_HOLD,
        ST_OWN,
        ST_LOW,
        ST_HIGH,
        ST_SETUP,
        ST_BUSFREE
    } state_e;

endpackage

// File: rtl/sclgen_cfg.sv
module sclgen_cfg #(
    parameter int CW = 16
) (
    input  logic [CW-1:0] raw_period,
    input  logic [CW-1:0] raw_low,
    input  logic [CW-1:0] raw_cond,
    input  logic [CW-1:0] raw_dsetup,
    output logic [CW-1:0] eff_low,
    output logic [CW-1:0] eff_high,
    output logic [CW-1:0] eff_cond,
    output logic [CW-1:0] eff_dpos
);
    localparam int          NF  = 4;
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    logic [NF-1:0][CW-1:0] raw_vec;
    logic [NF-1:0][CW-1:0] clamped;

    assign raw_vec = {raw_dsetup, raw_cond, raw_low, raw_period};

    for (genvar gi = 0; gi < NF; gi++) begin : g_clamp
        assign clamped[gi] = (raw_vec[gi] == '0) ? ONE : raw_vec[gi];
    end

    // index 0 period, 1 low, 2 condition, 3 data setup
    assign eff_low  = clamped[1];
    assign eff_cond = clamped[2];
    assign eff_high = (clamped[0] > clamped[1]) ? (clamped[0] - clamped[1]) : ONE;
    assign eff_dpos = (clamped[3] < clamped[1]) ? clamped[3] : (clamped[1] - ONE);

endmodule

// File: rtl/sclgen_fsm.sv
module sclgen_fsm
    import sclgen_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_code,
    input  logic [CW-1:0] eff_low,
    input  logic [CW-1:0] eff_high,
    input  logic [CW-1:0] eff_cond,
    input  logic [CW-1:0] eff_dpos,
    output logic          cmd_ready,
    output logic          scl_o,
    output logic          tick_sda,
    output logic          tick_rise,
    output logic          tick_sample,
    output logic          tick_cond
);
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    state_e        state, state_n;
    cmd_e          op, op_n;
    logic [CW-1:0] cnt, cnt_n;
    logic          accept;
    logic          cnt_zero;

    assign accept   = cmd_valid && cmd_ready;
    assign cnt_zero = (cnt == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            op    <= CMD_BIT;
            cnt   <= '0;
        end else begin
            state <= state_n;
            op    <= op_n;
            cnt   <= cnt_n;
        end
    end

    // next state and counter
    always_comb begin
        state_n = state;
        op_n    = op;
        cnt_n   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (accept && cmd_e'(cmd_code) == CMD_START) begin
                    state_n = ST_EDGE;
                    op_n    = CMD_START;
                end
            end
            ST_OWN: begin
                if (accept && cmd_e'(cmd_code) != CMD_START) begin
                    state_n = ST_LOW;
                    op_n    = cmd_e'(cmd_code);
                    cnt_n   = eff_low - ONE;
                end
            end
            ST_LOW: begin
                if (cnt_zero) begin
                    if (op == CMD_BIT) begin
                        state_n = ST_HIGH;
                        cnt_n   = eff_high - ONE;
                    end else begin
                        state_n = ST_SETUP;
                        cnt_n   = eff_cond - ONE;
                    end
                end else begin
                    cnt_n = cnt - ONE;
                end
            end
            ST_HIGH: begin
                if (cnt_zero) state_n = ST_OWN;
                else          cnt_n   = cnt - ONE;
            end
            ST_SETUP: begin
                if (cnt_zero) state_n = ST_EDGE;
                else          cnt_n   = cnt - ONE;
            end
            ST_EDGE: begin
                if (op == CMD_STOP) begin
                    state_n = ST_BUSFREE;
                    cnt_n   = eff_low - ONE;
                end else begin
                    state_n = ST_HOLD;
                    cnt_n   = eff_cond - ONE;
                end
            end
            ST_HOLD: begin
                if (cnt_zero) state_n = ST_OWN;
                else          cnt_n   = cnt - ONE;
            end
            ST_BUSFREE: begin
                if (cnt_zero) state_n = ST_IDLE;
                else          cnt_n   = cnt - ONE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_ready   = 1'b0;
        scl_o       = 1'b1;
        tick_sda    = 1'b0;
        tick_rise   = 1'b0;
        tick_sample = 1'b0;
        tick_cond   = 1'b0;
        unique case (state)
            ST_IDLE, ST_OWN: cmd_ready = 1'b1;
            ST_LOW: begin
                scl_o    = 1'b0;
                tick_sda = (cnt == eff_dpos);
            end
            ST_HIGH: begin
                tick_rise   = (cnt == eff_high - ONE);
                tick_sample = cnt_zero;
            end
            ST_SETUP: tick_rise = (cnt == eff_cond - ONE);
            ST_EDGE:  tick_cond = 1'b1;
            ST_HOLD, ST_BUSFREE: ;
            default: ;
        endcase
    end

    AST_FALL_FROM_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_o) |-> $past(state) == ST_OWN); // R4

    AST_RISE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        tick_rise |-> scl_o && !$past(scl_o)); // R4

    AST_SDA_ONLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        tick_sda |-> !scl_o); // R5

    AST_COND_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tick_cond |-> scl_o && $past(scl_o)); // R3

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OWN && cmd_valid && cmd_e'(cmd_code) == CMD_START) |=> state == ST_OWN); // R8

    AST_LOW_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_LOW |-> cnt < eff_low); // R2

    AST_SAMPLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tick_sample |-> scl_o && $past(state) != ST_SETUP); // R9

endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cfg_period,
    input  logic [CW-1:0] cfg_low,
    input  logic [CW-1:0] cfg_cond,
    input  logic [CW-1:0] cfg_dsetup,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_code,
    output logic          cmd_ready,
    output logic          scl_o,
    output logic          tick_sda,
    output logic          tick_rise,
    output logic          tick_sample,
    output logic          tick_cond
);
    logic [CW-1:0] eff_low, eff_high, eff_cond, eff_dpos;

    sclgen_cfg #(.CW(CW)) u_cfg (
        .raw_period (cfg_period),
        .raw_low    (cfg_low),
        .raw_cond   (cfg_cond),
        .raw_dsetup (cfg_dsetup),
        .eff_low    (eff_low),
        .eff_high   (eff_high),
        .eff_cond   (eff_cond),
        .eff_dpos   (eff_dpos)
    );

    sclgen_fsm #(.CW(CW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_code    (cmd_code),
        .eff_low     (eff_low),
        .eff_high    (eff_high),
        .eff_cond    (eff_cond),
        .eff_dpos    (eff_dpos),
        .cmd_ready   (cmd_ready),
        .scl_o       (scl_o),
        .tick_sda    (tick_sda),
        .tick_rise   (tick_rise),
        .tick_sample (tick_sample),
        .tick_cond   (tick_cond)
    );

endmodule

// File: tb/scl_phase_gen_bench.sv
module scl_phase_gen_bench;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cfg_period = '0, cfg_low = '0, cfg_cond = '0, cfg_dsetup = '0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_code = 2'd0;
    logic          cmd_ready, scl_o, tick_sda, tick_rise, tick_sample, tick_cond;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit mon_en = 1'b0;
    bit finished = 1'b0;
    logic scl_prev = 1'b1;

    typedef struct {
        int    cyc;
        int    kind;
        string req;
    } ev_t;
    ev_t q[$];

    // kinds: 0 SCL fall, 1 SCL rise, 2 sda, 3 rise tick, 4 sample, 5 cond
    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    scl_phase_gen #(.CW(CW)) u_scl_phase_gen (
        .clk(clk), .rst_n(rst_n),
        .cfg_period(cfg_period), .cfg_low(cfg_low),
        .cfg_cond(cfg_cond), .cfg_dsetup(cfg_dsetup),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_ready(cmd_ready),
        .scl_o(scl_o), .tick_sda(tick_sda), .tick_rise(tick_rise),
        .tick_sample(tick_sample), .tick_cond(tick_cond)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int clamp1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic void push(input int c, input int k, input string req);
        ev_t e;
        e.cyc = c; e.kind = k; e.req = req;
        q.push_back(e);
    endfunction

    // monitor: pops expected items as strobes and edges appear
    always @(negedge clk) begin
        if (mon_en) begin
            logic [5:0] obs;
            obs = {tick_cond, tick_sample, tick_rise, tick_sda,
                   (scl_o && !scl_prev), (!scl_o && scl_prev)};
            for (int k = 0; k < 6; k++) begin
                if (obs[k]) begin
                    if (q.size() == 0) begin
                        check(1'b0, "R8 unexpected event", k, -1);
                    end else begin
                        ev_t e;
                        e = q.pop_front();
                        check(e.kind == k, e.req, k, e.kind);
                        check(e.cyc == cyc, e.req, cyc, e.cyc);
                    end
                end
            end
            while (q.size() > 0 && q[0].cyc < cyc) begin
                ev_t e;
                e = q.pop_front();
                check(1'b0, e.req, -1, e.kind);
            end
        end
        scl_prev = scl_o;
    end

    task automatic issue(input int code, input string req);
        int c, p, l, s, d, h, dpos, ready_at;
        p = clamp1(int'(cfg_period)); l = clamp1(int'(cfg_low));
        s = clamp1(int'(cfg_cond));   d = clamp1(int'(cfg_dsetup));
        h = (p > l) ? p - l : 1;
        dpos = (d < l) ? d : l - 1;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        c = cyc;
        if (code == 0) begin
            push(c + 1, 5, {req, " R3 start edge"});
            ready_at = c + s + 2;
        end else begin
            push(c + 1, 0, {req, " R4 scl fall"});
            push(c + l - dpos, 2, {req, " R5 sda point"});
            push(c + l + 1, 1, {req, " R4 scl rise"});
            push(c + l + 1, 3, {req, " R4 rise tick"});
            if (code == 1) begin
                push(c + l + h, 4, {req, " R4 R9 sample"});
                ready_at = c + l + h + 1;
            end else begin
                push(c + l + s + 1, 5, {req, " R6 R7 cond edge"});
                ready_at = (code == 2) ? c + l + 2 * s + 2 : c + 2 * l + s + 2;
            end
        end
        cmd_valid = 1'b1;
        cmd_code  = code[1:0];
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!cmd_ready) @(negedge clk);
        check(cyc == ready_at, {req, " ready return R3 R4 R6 R7"}, cyc, ready_at);
    endtask

    task automatic ignored(input int code, input string req);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = code[1:0];
        @(negedge clk);
        cmd_valid = 1'b0;
        check(cmd_ready == 1'b1, {req, " R8 ready kept"}, int'(cmd_ready), 1);
        check(scl_o == 1'b1, {req, " R8 scl kept"}, int'(scl_o), 1);
        repeat (4) @(negedge clk);
        check(cmd_ready == 1'b1 && q.size() == 0, {req, " R8 still quiet"}, int'(cmd_ready), 1);
    endtask

    task automatic set_cfg(input int p, input int l, input int s, input int d);
        cfg_period = CW'(p); cfg_low = CW'(l); cfg_cond = CW'(s); cfg_dsetup = CW'(d);
    endtask

    task automatic frame(input string req);
        issue(0, req);
        issue(1, req);
        issue(1, req);
        issue(2, req);
        issue(1, req);
        issue(3, req);
    endtask

    initial begin
        set_cfg(20, 11, 10, 3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(scl_o == 1'b1, "R1 scl", int'(scl_o), 1);
        check(cmd_ready == 1'b1, "R1 ready", int'(cmd_ready), 1);
        check({tick_sda, tick_rise, tick_sample, tick_cond} == 4'b0, "R1 strobes",
              int'({tick_sda, tick_rise, tick_sample, tick_cond}), 0);
        mon_en = 1'b1;

        ignored(1, "idle bit");
        ignored(3, "idle stop");
        frame("cfgA");
        // START while owned is ignored
        issue(0, "cfgA2");
        ignored(0, "own start");
        issue(3, "cfgA2");

        set_cfg(20, 10, 4, 15);   // R5 data setup not below low
        frame("cfgB");
        set_cfg(8, 12, 2, 2);     // R9 low not below period
        frame("cfgC");
        set_cfg(0, 0, 0, 0);      // R2 all zero
        frame("cfgD");
        set_cfg(9, 5, 4, 1);
        frame("cfgE");

        repeat (5) @(negedge clk);
        check(q.size() == 0, "R4 queue drained", q.size(), 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule